// File: doc/BRIEF.md
# Boot-Block Flash Command Controller

This block is a cycle-based model of the command logic inside an 8 Mbit boot-block flash memory. Command bytes arrive on the low byte of a synchronous write port and move the controller between array-read, identify and status-read modes. Program and block-erase each need a setup write followed by a confirm write. The controller checks the program-voltage flag, the write-protect input and a high-voltage reset flag before it starts the operation. It then stays busy for a fixed number of cycles and commits the change to a small behavioural store.

Word addresses are 19 bits wide and fall into eleven erase blocks. Seven of them are 64K-word main blocks. There is also one 48K-word main block, two 4K-word parameter blocks and one 8K-word protected boot block. A parameter places the boot block at the top of the address space (block 10, words 7E000h–7FFFFh) or at the bottom (block 0, words 00000h–01FFFh). Blocks are numbered in ascending address order. The store keeps 2^SLOT_BITS words per block, selected by the low address bits. Words of one block that share those bits alias onto the same slot.

Top module: `boot_flash_ctrl`

## Requirements
- R1: While rst_n is low, status reads 80h and busy is 0. After release the controller is in array-read mode with no setup pending, so a confirm byte written next is treated as an unknown command.
- R2: Writing 90h enters identify mode. There, a read with rd_addr[0]=0 returns 0089h. A read with rd_addr[0]=1 returns 889Ch in top-boot layout and 889Dh in bottom-boot layout.
- R3: An erase is the byte 20h followed by a D0h write whose address picks the block. When it completes, every word of that block reads FFFFh and no other block changes.
- R4: A program is the byte 10h or 40h followed by a write of address and data. When it completes, the addressed word holds the old word AND the written data.
- R5: busy rises on the edge of an accepted confirm and stays high for exactly BUSY_CYCLES clock cycles. Writes that arrive while busy is high are ignored.
- R6: After any confirm write, whether it starts an operation or is refused, reads return {8'h00, status} until a mode command is written. Writing 70h also selects this mode. A pending setup reads status as well.
- R7: Status bit 7 is ready, which is the inverse of busy. If the write after an erase setup carries any byte other than D0h, bits 5 (erase error) and 4 (program error) are set and no operation starts.
- R8: A program or erase whose address lies in the boot block starts only when wp or rst_hv is high. Otherwise it sets bit 1 (locked) together with the error bit of that operation. Blocks other than the boot block ignore wp.
- R9: If vpp_ok is low at the confirm, the operation does not start and bit 3 (voltage) is set together with its error bit. This check takes precedence over the lock check. If vpp_ok falls while busy, the operation aborts on the next edge with the same bits set, and the array is unchanged.
- R10: Error bits stay set until reset or until the byte 50h is written. Writing 50h clears bits 5, 4, 3 and 1 and leaves the read mode unchanged.
- R11: A byte that is not FFh, 90h, 70h, 50h, 20h, 10h or 40h, written outside a setup, changes neither the mode nor the status.
- R12: In top layout, blocks 0–6 are 64K-word blocks from 00000h, block 7 covers 70000h–7BFFFh, blocks 8 and 9 cover 7C000h and 7D000h, and block 10 is the boot block. In bottom layout, block 0 (boot) covers 00000h–01FFFh, blocks 1 and 2 cover 02000h and 03000h, block 3 covers 04000h–0FFFFh, and blocks 4–10 are the 64K-word blocks from 10000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears status and forces array-read mode |
| rst_hv | input | 1 | Reset input held at the high-voltage level; unlocks the boot block |
| wp | input | 1 | Write-protect release for the boot block (high = writable) |
| vpp_ok | input | 1 | Program-voltage valid |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 19 | Word address of the write |
| wr_data | input | 16 | Write data; the low byte carries commands |
| rd_addr | input | 19 | Read word address |
| rd_data | output | 16 | Read data for the current mode |
| busy | output | 1 | Program or erase in progress |
| status | output | 8 | Status register: 7 ready, 5 erase error, 4 program error, 3 voltage, 1 locked |

## Verification
The assertions assume a reset pulse of several cycles at the start of the run. They also assume that wp, rst_hv and vpp_ok change only between edges, so each flag is sampled once at the confirm and on every busy edge. The stimulus changes these flags only on falling clock edges and starts every run with the store fully erased. Random flags are chosen before each command pair, and vpp_ok is dropped during busy only in a directed test. Two instances, one per layout, receive the same stimulus, so each lock or block-map difference shows up as a difference between their outputs.

// File: rtl/flashctl_pkg.sv
package flashctl_pkg;

  localparam int WADDR_W  = 19;
  localparam int DATA_W   = 16;
  localparam int NUM_BLKS = 11;
  localparam int BLK_W    = 4;

  typedef enum logic [2:0] {
    M_ARRAY, M_IDENT, M_STATUS, M_ERASE_SU, M_PROG_SU, M_BUSY
  } mode_e;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_STAT    = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_PROG_A  = 8'h10;
  localparam logic [7:0] CMD_PROG_B  = 8'h40;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;

  // Block index of a word address, blocks numbered in ascending address order.
  function automatic logic [BLK_W-1:0] blk_of(input logic [WADDR_W-1:0] a, input logic top);
    logic [BLK_W-1:0] b;
    if (top) begin
      if (a[18:16] != 3'b111)      b = {1'b0, a[18:16]};
      else if (a[15:14] != 2'b11)  b = 4'd7;
      else if (a[13])              b = 4'd10;
      else                         b = a[12] ? 4'd9 : 4'd8;
    end else begin
      if (a[18:16] != 3'b000)      b = 4'd3 + {1'b0, a[18:16]};
      else if (a[15:14] != 2'b00)  b = 4'd3;
      else if (!a[13])             b = 4'd0;
      else                         b = a[12] ? 4'd2 : 4'd1;
    end
    return b;
  endfunction

  function automatic logic [BLK_W-1:0] boot_idx(input logic top);
    return top ? 4'd10 : 4'd0;
  endfunction

  function automatic logic [DATA_W-1:0] ident_word(input logic a0, input logic top);
    if (!a0) return 16'h0089;
    return {8'h88, (top ? 8'h9C : 8'h9D)};
  endfunction

endpackage

// File: rtl/fc_block_map.sv
module fc_block_map
  import flashctl_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic [WADDR_W-1:0] addr,
  output logic [BLK_W-1:0]   blk
);
  assign blk = blk_of(addr, TOP_BOOT);
endmodule

// File: rtl/fc_array.sv
module fc_array
  import flashctl_pkg::*;
#(
  parameter int SLOT_BITS = 2
) (
  input  logic                 clk,
  input  logic                 apply,
  input  logic                 erase,
  input  logic [BLK_W-1:0]     wblk,
  input  logic [SLOT_BITS-1:0] wslot,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [BLK_W-1:0]     rblk,
  input  logic [SLOT_BITS-1:0] rslot,
  output logic [DATA_W-1:0]    rword
);
  localparam int SLOTS = 1 << SLOT_BITS;
  localparam int WORDS = NUM_BLKS * SLOTS;
  localparam int IDX_W = $clog2(WORDS);

  logic [DATA_W-1:0] mem [WORDS];
  logic [IDX_W-1:0]  widx, ridx;

  assign widx  = IDX_W'(int'(wblk) * SLOTS + int'(wslot));
  assign ridx  = IDX_W'(int'(rblk) * SLOTS + int'(rslot));
  assign rword = mem[ridx];

  always_ff @(posedge clk) begin
    if (apply) begin
      if (erase) begin
        for (int s = 0; s < SLOTS; s++) begin
          mem[IDX_W'(int'(wblk) * SLOTS + s)] <= '1;
        end
      end else begin
        mem[widx] <= mem[widx] & wdata;
      end
    end
  end
endmodule

// File: rtl/fc_cmd_fsm.sv
module fc_cmd_fsm
  import flashctl_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               vpp_ok,
  input  logic               boot_hit,
  input  logic               unlock,
  output mode_e              mode,
  output logic               busy,
  output logic [7:0]         status,
  output logic               apply,
  output logic               op_erase,
  output logic [WADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0]  op_data,
  output logic               start_op,
  output logic               abort_op,
  output logic               bad_confirm,
  output logic               clear_req
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt;
  logic err_erase, err_prog, err_vpp, err_lock;
  logic [7:0] cmd;
  logic in_setup, setup_erase, confirm_cyc, good_confirm, vpp_fail, lock_fail;

  always_comb begin
    cmd          = wr_data[7:0];
    in_setup     = (mode == M_ERASE_SU) || (mode == M_PROG_SU);
    setup_erase  = (mode == M_ERASE_SU);
    confirm_cyc  = wr_en && !busy && in_setup;
    bad_confirm  = confirm_cyc && setup_erase && (cmd != CMD_CONFIRM);
    good_confirm = confirm_cyc && !bad_confirm;
    vpp_fail     = good_confirm && !vpp_ok;
    lock_fail    = good_confirm && vpp_ok && boot_hit && !unlock;
    start_op     = good_confirm && vpp_ok && !(boot_hit && !unlock);
    abort_op     = busy && !vpp_ok;
    apply        = busy && vpp_ok && (cnt == '0);
    clear_req    = wr_en && !busy && !in_setup && (cmd == CMD_CLEAR);
    status       = {!busy, 1'b0, err_erase, err_prog, err_vpp, 1'b0, err_lock, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_ARRAY;
      busy      <= 1'b0;
      cnt       <= '0;
      err_erase <= 1'b0;
      err_prog  <= 1'b0;
      err_vpp   <= 1'b0;
      err_lock  <= 1'b0;
      op_erase  <= 1'b0;
      op_addr   <= '0;
      op_data   <= '0;
    end else if (busy) begin
      if (abort_op) begin
        busy    <= 1'b0;
        mode    <= M_STATUS;
        err_vpp <= 1'b1;
        if (op_erase) err_erase <= 1'b1;
        else          err_prog  <= 1'b1;
      end else if (cnt == '0) begin
        busy <= 1'b0;
        mode <= M_STATUS;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (wr_en) begin
      if (in_setup) begin
        mode <= M_STATUS;
        if (bad_confirm) begin
          err_erase <= 1'b1;
          err_prog  <= 1'b1;
        end else if (vpp_fail || lock_fail) begin
          if (vpp_fail) err_vpp  <= 1'b1;
          else          err_lock <= 1'b1;
          if (setup_erase) err_erase <= 1'b1;
          else             err_prog  <= 1'b1;
        end else begin
          busy     <= 1'b1;
          mode     <= M_BUSY;
          cnt      <= CNT_W'(BUSY_CYCLES - 1);
          op_erase <= setup_erase;
          op_addr  <= wr_addr;
          op_data  <= wr_data;
        end
      end else begin
        case (cmd)
          CMD_ARRAY:              mode <= M_ARRAY;
          CMD_IDENT:              mode <= M_IDENT;
          CMD_STAT:               mode <= M_STATUS;
          CMD_ERASE:              mode <= M_ERASE_SU;
          CMD_PROG_A, CMD_PROG_B: mode <= M_PROG_SU;
          CMD_CLEAR: begin
            err_erase <= 1'b0;
            err_prog  <= 1'b0;
            err_vpp   <= 1'b0;
            err_lock  <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/boot_flash_ctrl.sv
module boot_flash_ctrl
  import flashctl_pkg::*;
#(
  parameter bit TOP_BOOT    = 1'b1,
  parameter int BUSY_CYCLES = 8,
  parameter int SLOT_BITS   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rst_hv,
  input  logic        wp,
  input  logic        vpp_ok,
  input  logic        wr_en,
  input  logic [18:0] wr_addr,
  input  logic [15:0] wr_data,
  input  logic [18:0] rd_addr,
  output logic [15:0] rd_data,
  output logic        busy,
  output logic [7:0]  status
);
  localparam logic [BLK_W-1:0] BOOT_BLK = boot_idx(TOP_BOOT);
  localparam int NMAP = 3;

  mode_e               mode;
  logic                apply, op_erase, start_op, abort_op, bad_confirm, clear_req;
  logic                boot_hit;
  logic [WADDR_W-1:0]  op_addr;
  logic [DATA_W-1:0]   op_data, arr_word;
  logic [WADDR_W-1:0]  map_addr [NMAP];
  logic [BLK_W-1:0]    map_blk  [NMAP];

  // 0: incoming write, 1: latched operation, 2: read port
  assign map_addr[0] = wr_addr;
  assign map_addr[1] = op_addr;
  assign map_addr[2] = rd_addr;

  for (genvar i = 0; i < NMAP; i++) begin : g_map
    fc_block_map #(.TOP_BOOT(TOP_BOOT)) u_map (
      .addr (map_addr[i]),
      .blk  (map_blk[i])
    );
  end

  assign boot_hit = (map_blk[0] == BOOT_BLK);

  fc_cmd_fsm #(.BUSY_CYCLES(BUSY_CYCLES)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .vpp_ok      (vpp_ok),
    .boot_hit    (boot_hit),
    .unlock      (wp || rst_hv),
    .mode        (mode),
    .busy        (busy),
    .status      (status),
    .apply       (apply),
    .op_erase    (op_erase),
    .op_addr     (op_addr),
    .op_data     (op_data),
    .start_op    (start_op),
    .abort_op    (abort_op),
    .bad_confirm (bad_confirm),
    .clear_req   (clear_req)
  );

  fc_array #(.SLOT_BITS(SLOT_BITS)) u_array (
    .clk   (clk),
    .apply (apply),
    .erase (op_erase),
    .wblk  (map_blk[1]),
    .wslot (op_addr[SLOT_BITS-1:0]),
    .wdata (op_data),
    .rblk  (map_blk[2]),
    .rslot (rd_addr[SLOT_BITS-1:0]),
    .rword (arr_word)
  );

  always_comb begin
    case (mode)
      M_ARRAY: rd_data = arr_word;
      M_IDENT: rd_data = ident_word(rd_addr[0], TOP_BOOT);
      default: rd_data = {8'h00, status};
    endcase
  end
endmodule

// File: rtl/boot_flash_ctrl_chk.sv
module boot_flash_ctrl_chk #(
  parameter int BUSY_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_hv,
  input logic       wp,
  input logic       vpp_ok,
  input logic       busy,
  input logic [7:0] status,
  input logic       start_op,
  input logic       abort_op,
  input logic       apply,
  input logic       bad_confirm,
  input logic       clear_req,
  input logic       boot_hit
);
  logic rst_seen;
  int   bcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) rst_seen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bcnt <= 0;
    else if (!busy) bcnt <= 0;
    else            bcnt <= bcnt + 1;
  end

  always @(posedge clk) begin
    if (!rst_n && rst_seen) begin
      a_r1_reset_state: assert (status == 8'h80 && !busy)
        else $error("reset state wrong");
    end
  end

  a_r5_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_op |=> busy);
  a_r5_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_op);
  a_r5_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> (bcnt == BUSY_CYCLES - 1));
  a_r7_bad_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    bad_confirm |=> (status[5] && status[4] && !busy));
  a_r8_boot_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    (start_op && boot_hit) |-> (wp || rst_hv));
  a_r9_confirm_vpp: assert property (@(posedge clk) disable iff (!rst_n)
    start_op |-> vpp_ok);
  a_r9_abort_flags: assert property (@(posedge clk) disable iff (!rst_n)
    abort_op |=> (!busy && status[3]));
  a_r10_sticky_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (status[5] && !clear_req) |=> status[5]);
endmodule

bind boot_flash_ctrl boot_flash_ctrl_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rst_hv      (rst_hv),
  .wp          (wp),
  .vpp_ok      (vpp_ok),
  .busy        (busy),
  .status      (status),
  .start_op    (start_op),
  .abort_op    (abort_op),
  .apply       (apply),
  .bad_confirm (bad_confirm),
  .clear_req   (clear_req),
  .boot_hit    (boot_hit)
);

// File: tb/boot_flash_ctrl_tb.sv
module boot_flash_ctrl_tb;
  localparam int PERIOD = 10;
  localparam int BUSY   = 5;
  localparam int SLOTS  = 4;
  localparam int NW     = 11 * SLOTS;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic        rst_n, rst_hv, wp, vpp_ok, wr_en;
  logic [18:0] wr_addr, rd_addr;
  logic [15:0] wr_data;
  logic [15:0] rd_t, rd_b;
  logic        busy_t, busy_b;
  logic [7:0]  st_t, st_b;

  int checks = 0;
  int fails  = 0;

  logic [15:0] mm [2][NW];
  int          mmode [2];
  logic [3:0]  merr [2];  // [3] erase, [2] program, [1] voltage, [0] locked
  bit          pst [2];
  logic [18:0] pa [2];
  logic [15:0] pd [2];
  bit          pe [2];

  boot_flash_ctrl #(.TOP_BOOT(1'b1), .BUSY_CYCLES(BUSY), .SLOT_BITS(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .rst_hv(rst_hv), .wp(wp), .vpp_ok(vpp_ok),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_t), .busy(busy_t), .status(st_t));

  boot_flash_ctrl #(.TOP_BOOT(1'b0), .BUSY_CYCLES(BUSY), .SLOT_BITS(2)) u_dut_bot (
    .clk(clk), .rst_n(rst_n), .rst_hv(rst_hv), .wp(wp), .vpp_ok(vpp_ok),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_b), .busy(busy_b), .status(st_b));

  // R12 block map, restated as address ranges
  function automatic int f_blk(logic [18:0] a, bit top);
    int x = int'(a);
    if (top) begin
      if (x < 'h70000) return x / 'h10000;
      if (x < 'h7C000) return 7;
      if (x < 'h7D000) return 8;
      if (x < 'h7E000) return 9;
      return 10;
    end
    if (x < 'h02000) return 0;
    if (x < 'h03000) return 1;
    if (x < 'h04000) return 2;
    if (x < 'h10000) return 3;
    return 3 + x / 'h10000;
  endfunction

  function automatic logic [15:0] f_status(int d);
    return {8'h00, 1'b1, 1'b0, merr[d][3], merr[d][2], merr[d][1], 1'b0, merr[d][0], 1'b0};
  endfunction

  function automatic logic [15:0] f_read(int d, logic [18:0] a);
    if (mmode[d] == 0) return mm[d][f_blk(a, d == 0) * SLOTS + int'(a[1:0])];
    if (mmode[d] == 1) return a[0] ? ((d == 0) ? 16'h889C : 16'h889D) : 16'h0089;
    return f_status(d);
  endfunction

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic set_op_err(int d, bit e);
    if (e) merr[d][3] = 1'b1;
    else   merr[d][2] = 1'b1;
  endtask

  task automatic m_write(int d, logic [18:0] a, logic [15:0] v);
    bit e;
    if (mmode[d] == 3 || mmode[d] == 4) begin
      e = (mmode[d] == 3);
      mmode[d] = 2;
      if (e && v[7:0] != 8'hD0) begin
        merr[d][3] = 1'b1; merr[d][2] = 1'b1;
      end else if (!vpp_ok) begin
        merr[d][1] = 1'b1; set_op_err(d, e);
      end else if (f_blk(a, d == 0) == ((d == 0) ? 10 : 0) && !(wp || rst_hv)) begin
        merr[d][0] = 1'b1; set_op_err(d, e);
      end else begin
        pst[d] = 1'b1; pa[d] = a; pd[d] = v; pe[d] = e;
      end
    end else begin
      case (v[7:0])
        8'hFF: mmode[d] = 0;
        8'h90: mmode[d] = 1;
        8'h70: mmode[d] = 2;
        8'h20: mmode[d] = 3;
        8'h10, 8'h40: mmode[d] = 4;
        8'h50: merr[d] = '0;
        default: ;
      endcase
    end
  endtask

  task automatic m_apply(int d);
    int b;
    if (pst[d]) begin
      b = f_blk(pa[d], d == 0);
      if (pe[d]) begin
        for (int s = 0; s < SLOTS; s++) mm[d][b * SLOTS + s] = 16'hFFFF;
      end else begin
        mm[d][b * SLOTS + int'(pa[d][1:0])] = mm[d][b * SLOTS + int'(pa[d][1:0])] & pd[d];
      end
      pst[d] = 1'b0;
    end
  endtask

  task automatic wr_raw(logic [18:0] a, logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic run_busy(bit cnt_chk);
    int n0 = 0;
    int n1 = 0;
    for (int g = 0; g < 100; g++) begin
      if (!busy_t && !busy_b) break;
      n0 += int'(busy_t);
      n1 += int'(busy_b);
      @(negedge clk); #1;
    end
    if (cnt_chk) begin
      chk("R5 busy length top", 16'(n0), pst[0] ? 16'(BUSY) : 16'd0);
      chk("R5 busy length bottom", 16'(n1), pst[1] ? 16'(BUSY) : 16'd0);
    end
    m_apply(0);
    m_apply(1);
  endtask

  task automatic do_write(logic [18:0] a, logic [15:0] v);
    wr_raw(a, v);
    m_write(0, a, v);
    m_write(1, a, v);
    run_busy(1'b1);
  endtask

  task automatic rd_chk(logic [18:0] a, string req);
    rd_addr = a;
    #1;
    chk({req, " top"}, rd_t, f_read(0, a));
    chk({req, " bottom"}, rd_b, f_read(1, a));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset status top", {8'h00, st_t}, 16'h0080);
    chk("R1 reset status bottom", {8'h00, st_b}, 16'h0080);
    chk("R1 reset busy", {14'd0, busy_t, busy_b}, 16'd0);
    for (int d = 0; d < 2; d++) begin
      mmode[d] = 0; merr[d] = '0; pst[d] = 1'b0;
    end
    rst_n = 1'b1;
    #1;
  endtask

  // Watchdog: a hang counts as a failure and still reports.
  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog R5 got=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [18:0] edge_a [8];
    logic [7:0]  junk [6];
    logic [18:0] a;
    logic [15:0] v;
    edge_a = '{19'h7E001, 19'h7DFFF, 19'h7C002, 19'h7BFFF, 19'h01FFF, 19'h02000, 19'h0FFFE, 19'h10003};
    junk   = '{8'h00, 8'h01, 8'hA5, 8'h33, 8'hD0, 8'hFE};
    void'($urandom(32'h5EED));
    rst_n = 1'b0; rst_hv = 1'b0; wp = 1'b1; vpp_ok = 1'b1; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    do_reset();
    rd_chk(19'h0, "R1 reset reads status bits");

    // Erase the whole store in both layouts (R3).
    for (int x = 0; x < 'h80000; x += 'h1000) begin
      do_write(19'(x), 16'h0020);
      do_write(19'(x), 16'h00D0);
    end
    rd_chk(19'h12340, "R6 status after erase");
    do_write(19'h0, 16'h00FF);
    rd_chk(19'h7E003, "R3 erased boot");
    rd_chk(19'h00002, "R3 erased low");

    // R2 identify
    do_write(19'h0, 16'h0090);
    rd_chk(19'h00000, "R2 manufacturer");
    rd_chk(19'h00001, "R2 device");
    rd_chk(19'h12345, "R2 device high addr");

    // R4 / R6 program, AND behaviour
    do_write(19'h30001, 16'h0040);
    rd_chk(19'h30001, "R6 setup reads status");
    do_write(19'h30001, 16'h1234);
    rd_chk(19'h30001, "R6 status after program");
    do_write(19'h0, 16'h00FF);
    rd_chk(19'h30001, "R4 program");
    do_write(19'h30001, 16'h0010);
    do_write(19'h30001, 16'hFF0F);
    do_write(19'h0, 16'h00FF);
    rd_chk(19'h30001, "R4 program and");

    // R3 erase of one block only
    do_write(19'h20001, 16'h0040);
    do_write(19'h20001, 16'h0000);
    do_write(19'h3FFF0, 16'h0020);
    do_write(19'h3FFF0, 16'h00D0);
    do_write(19'h0, 16'h00FF);
    rd_chk(19'h30001, "R3 erased target");
    rd_chk(19'h20001, "R3 neighbour kept");

    // R7 bad confirm, R10 sticky and clear
    do_write(19'h40000, 16'h0020);
    do_write(19'h40000, 16'h0011);
    rd_chk(19'h0, "R7 bad confirm status");
    do_write(19'h0, 16'h00FF);
    do_write(19'h0, 16'h0070);
    rd_chk(19'h0, "R10 errors sticky");
    do_write(19'h0, 16'h0050);
    rd_chk(19'h0, "R10 cleared, mode kept");

    // R11 unrecognised byte
    do_write(19'h0, 16'h00FF);
    do_write(19'h20001, 16'h00A5);
    rd_chk(19'h20001, "R11 ignored in array mode");
    do_write(19'h0, 16'h0090);
    do_write(19'h0, 16'h0033);
    rd_chk(19'h00001, "R11 ignored in identify mode");

    // R8 boot lock: address 7E010 is boot in top layout only
    wp = 1'b0; rst_hv = 1'b0;
    do_write(19'h7E010, 16'h0040);
    do_write(19'h7E010, 16'h0F0F);
    rd_chk(19'h0, "R8 locked top, open bottom");
    do_write(19'h0, 16'h0050);
    do_write(19'h0, 16'h00FF);
    rd_chk(19'h7E010, "R8 boot unchanged when locked");
    rst_hv = 1'b1;
    do_write(19'h7E010, 16'h0040);
    do_write(19'h7E010, 16'h00FF);
    do_write(19'h0, 16'h00FF);
    rd_chk(19'h7E010, "R8 high-voltage unlock");
    rst_hv = 1'b0;
    do_write(19'h00004, 16'h0020);
    do_write(19'h00004, 16'h00D0);
    rd_chk(19'h0, "R8 locked bottom erase");
    do_write(19'h0, 16'h0050);
    wp = 1'b1;
    do_write(19'h00004, 16'h0040);
    do_write(19'h00004, 16'h3C3C);
    do_write(19'h0, 16'h00FF);
    rd_chk(19'h00004, "R8 wp release");

    // R9 voltage low at confirm
    vpp_ok = 1'b0;
    do_write(19'h50002, 16'h0040);
    do_write(19'h50002, 16'h0000);
    rd_chk(19'h0, "R9 vpp at confirm");
    vpp_ok = 1'b1;
    do_write(19'h0, 16'h0050);
    // R9 voltage lost while busy
    do_write(19'h50002, 16'h0040);
    wr_raw(19'h50002, 16'h0000);
    m_write(0, 19'h50002, 16'h0000);
    m_write(1, 19'h50002, 16'h0000);
    vpp_ok = 1'b0;
    @(negedge clk); #1;
    chk("R9 abort ends busy", {14'd0, busy_t, busy_b}, 16'd0);
    for (int d = 0; d < 2; d++) begin
      pst[d] = 1'b0; merr[d][1] = 1'b1; merr[d][2] = 1'b1;
    end
    vpp_ok = 1'b1;
    rd_chk(19'h0, "R9 abort status");
    do_write(19'h0, 16'h0050);
    do_write(19'h0, 16'h00FF);
    rd_chk(19'h50002, "R9 array unchanged after abort");

    // R5 write during busy is ignored
    do_write(19'h60003, 16'h0040);
    wr_raw(19'h60003, 16'h5A5A);
    m_write(0, 19'h60003, 16'h5A5A);
    m_write(1, 19'h60003, 16'h5A5A);
    wr_raw(19'h0, 16'h00FF);
    run_busy(1'b0);
    rd_chk(19'h60003, "R5 write during busy ignored");
    do_write(19'h0, 16'h00FF);
    rd_chk(19'h60003, "R5 program after busy");

    // R12 block boundaries
    do_write(19'h7C000, 16'h0040);
    do_write(19'h7C000, 16'h0000);
    do_write(19'h7BFFC, 16'h0040);
    do_write(19'h7BFFC, 16'h0000);
    do_write(19'h02000, 16'h0040);
    do_write(19'h02000, 16'h0000);
    do_write(19'h7C003, 16'h0020);
    do_write(19'h7C003, 16'h00D0);
    do_write(19'h01FFF, 16'h0020);
    do_write(19'h01FFF, 16'h00D0);
    do_write(19'h0, 16'h00FF);
    rd_chk(19'h7C000, "R12 block 8 start");
    rd_chk(19'h7BFFC, "R12 block 7 end");
    rd_chk(19'h02000, "R12 parameter block start");

    // R1 reset drops a pending setup
    do_write(19'h40001, 16'h0020);
    do_reset();
    do_write(19'h40001, 16'h00D0);
    rd_chk(19'h40001, "R1 setup dropped by reset");

    // Constrained random mix (R3, R4, R6, R7, R8, R9, R10, R11)
    for (int i = 0; i < 250; i++) begin
      a = ($urandom % 4 == 0) ? edge_a[$urandom % 8] : 19'($urandom);
      v = 16'($urandom);
      wp     = 1'($urandom % 2);
      rst_hv = ($urandom % 4 == 0);
      vpp_ok = ($urandom % 8 != 0);
      case ($urandom % 7)
        0: begin do_write(a, ($urandom % 2) ? 16'h0040 : 16'h0010); do_write(a, v); end
        1: begin do_write(a, 16'h0020); do_write(a, 16'h00D0); end
        2: begin do_write(a, 16'h0020); do_write(a, (v[7:0] == 8'hD0) ? 16'h0001 : v); end
        3: do_write(a, 16'h0090);
        4: do_write(a, {8'h00, junk[$urandom % 6]});
        5: do_write(a, 16'h0050);
        default: do_write(a, 16'h0070);
      endcase
      vpp_ok = 1'b1;
      rd_chk(a, "R3/R4/R6 random read");
      if ($urandom % 2 == 1) do_write(19'h0, 16'h00FF);
      rd_chk(19'($urandom), "R12 random read");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule